// File: doc/BRIEF.md
# NAND Page Chunk ECC Syndrome Checker

This block closes the read path of a single-error-correcting, double-error-detecting Hamming scheme used on NAND flash data chunks of 256 or 512 bytes. After a chunk has been read, the 24-bit check code stored in the spare area and a code freshly computed over the data read back are presented together with a one-cycle check strobe. The block XORs them into a syndrome, counts its set bits, checks the complementarity of every parity pair and classifies the result as clean, a correctable single data bit fault, a fault in the stored check code itself, or uncorrectable.

For a correctable fault the block reports the byte offset inside the chunk and the bit position inside that byte, both read from the odd member of each parity pair. A combinational repair port then takes the data byte fetched from the reported offset and returns it with the faulty bit inverted. Reading and rewriting the page buffer belongs to the surrounding logic.

Code layout (both code inputs): bits 15:0 hold line parities L0..L15 (Lk at bit k), bit 16 holds L16, bit 17 holds L17, bits 23:18 hold column parities C0..C5 (Cj at bit 18+j). Pairs are (bit 2p, bit 2p+1).

Top module: `nand_ecc_locator`

## Requirements
- R1: A syndrome (stored XOR fresh, after masking) of all zeros yields status 2'd0 (clean).
- R2: A syndrome with exactly one set bit yields status 2'd2 (fault in the stored code; data good).
- R3: In 256-byte mode (wide_mode=0), a syndrome with exactly 11 ones in which all eight line pairs (bits 15:0) and all three column pairs (bits 23:18) are complementary yields status 2'd1 (correctable).
- R4: In 512-byte mode (wide_mode=1), a syndrome with exactly 12 ones in which all nine line pairs (bits 17:0) and all three column pairs are complementary yields status 2'd1.
- R5: For status 2'd1, res_byte bit k equals syndrome bit 2k+1 for k=0..7, and res_byte bit 8 equals syndrome bit 17 in 512-byte mode and is 0 in 256-byte mode.
- R6: For status 2'd1, res_bit equals {syndrome bit 23, bit 21, bit 19}, bit 23 as MSB.
- R7: Every other syndrome yields status 2'd3 (uncorrectable), including a correct population count with a non-complementary pair; whenever status is not 2'd1, res_byte and res_bit are 0.
- R8: In 256-byte mode bits 17:16 of both codes are ignored for classification and location.
- R9: res_valid is high for exactly the cycle after each chk_go cycle; results are captured on the strobe and held unchanged until the next strobe.
- R10: fix_out equals fix_in with bit res_bit inverted while status is 2'd1, and equals fix_in otherwise.
- R11: After reset res_valid is 0, status is 2'd0 and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_go | input | 1 | Check strobe, one cycle per chunk |
| wide_mode | input | 1 | 1 = 512-byte chunk, 0 = 256-byte chunk |
| code_stored | input | 24 | Check code read from the spare area |
| code_fresh | input | 24 | Check code recomputed over the data read |
| res_valid | output | 1 | One-cycle result pulse |
| res_status | output | 2 | 0 clean, 1 correctable, 2 code-field fault, 3 uncorrectable |
| res_byte | output | 9 | Faulty byte offset in the chunk |
| res_bit | output | 3 | Faulty bit inside the byte |
| fix_in | input | 8 | Data byte fetched from res_byte |
| fix_out | output | 8 | Repaired data byte |

## Verification
The repair port and a new classification can fall into the same cycle: a byte is presented on fix_in while chk_go is high for the next chunk, so the repair must still use the held result of the previous check while the new result is being captured. The bench provokes this by issuing back-to-back strobes with random repair bytes and compares fix_out against the model's held result, then compares the new status and addresses on the following cycle.

// File: rtl/nand_syn_pkg.sv
package nand_syn_pkg;
    localparam int LINE_PAIRS = 9;
    localparam int COL_PAIRS  = 3;
    localparam int CODE_W     = 2 * (LINE_PAIRS + COL_PAIRS);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIX   = 2'd1,
        ST_CODE  = 2'd2,
        ST_BAD   = 2'd3
    } chk_status_e;

    typedef struct packed {
        logic                  valid;
        chk_status_e           status;
        logic [LINE_PAIRS-1:0] byte_a;
        logic [COL_PAIRS-1:0]  bit_a;
    } chk_result_t;
endpackage

// File: rtl/syndrome_former.sv
module syndrome_former #(
    parameter int LP = nand_syn_pkg::LINE_PAIRS,
    parameter int CP = nand_syn_pkg::COL_PAIRS,
    localparam int W = 2 * (LP + CP)
) (
    input  logic [W-1:0] stored,
    input  logic [W-1:0] fresh,
    input  logic         wide,
    output logic [W-1:0] syn
);
    // The top line pair only exists for the long chunk.
    always_comb begin
        syn = stored ^ fresh;
        if (!wide) begin
            syn[2*LP-1 -: 2] = 2'b00;
        end
    end
endmodule

// File: rtl/syndrome_classifier.sv
module syndrome_classifier
    import nand_syn_pkg::*;
#(
    parameter int LP = nand_syn_pkg::LINE_PAIRS,
    parameter int CP = nand_syn_pkg::COL_PAIRS,
    localparam int W  = 2 * (LP + CP),
    localparam int NP = LP + CP,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0] syn,
    input  logic         wide,
    output chk_status_e  status
);
    localparam logic [CW-1:0] POP_WIDE   = CW'(NP);
    localparam logic [CW-1:0] POP_NARROW = CW'(NP - 1);
    localparam logic [NP-1:0] TOP_LINE   = NP'(1) << (LP - 1);

    logic [CW-1:0] ones;
    logic [NP-1:0] pair_diff;
    logic          pairs_ok;

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_pair
            assign pair_diff[p] = syn[2*p] ^ syn[2*p+1];
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(syn[i]);
        end
    end

    assign pairs_ok = wide ? (&pair_diff) : (&(pair_diff | TOP_LINE));

    always_comb begin
        if (ones == '0) begin
            status = ST_CLEAN;
        end else if (ones == CW'(1)) begin
            status = ST_CODE;
        end else if (pairs_ok && (ones == (wide ? POP_WIDE : POP_NARROW))) begin
            status = ST_FIX;
        end else begin
            status = ST_BAD;
        end
    end
endmodule

// File: rtl/fault_locator.sv
module fault_locator #(
    parameter int LP = nand_syn_pkg::LINE_PAIRS,
    parameter int CP = nand_syn_pkg::COL_PAIRS,
    localparam int W = 2 * (LP + CP)
) (
    input  logic [W-1:0]  syn,
    output logic [LP-1:0] byte_a,
    output logic [CP-1:0] bit_a
);
    genvar k;
    generate
        for (k = 0; k < LP; k++) begin : g_line
            assign byte_a[k] = syn[2*k+1];
        end
        for (k = 0; k < CP; k++) begin : g_col
            assign bit_a[k] = syn[2*LP+2*k+1];
        end
    endgenerate
endmodule

// File: rtl/nand_ecc_locator.sv
module nand_ecc_locator
    import nand_syn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chk_go,
    input  logic        wide_mode,
    input  logic [23:0] code_stored,
    input  logic [23:0] code_fresh,
    output logic        res_valid,
    output logic [1:0]  res_status,
    output logic [8:0]  res_byte,
    output logic [2:0]  res_bit,
    input  logic [7:0]  fix_in,
    output logic [7:0]  fix_out
);
    localparam int DW = 2 ** COL_PAIRS;

    logic [CODE_W-1:0]     syn;
    chk_status_e           cls_status;
    logic [LINE_PAIRS-1:0] loc_byte;
    logic [COL_PAIRS-1:0]  loc_bit;
    chk_result_t           res_d, res_q;
    logic [DW-1:0]         flip_mask;

    syndrome_former #(.LP(LINE_PAIRS), .CP(COL_PAIRS)) u_form (
        .stored (code_stored),
        .fresh  (code_fresh),
        .wide   (wide_mode),
        .syn    (syn)
    );

    syndrome_classifier #(.LP(LINE_PAIRS), .CP(COL_PAIRS)) u_cls (
        .syn    (syn),
        .wide   (wide_mode),
        .status (cls_status)
    );

    fault_locator #(.LP(LINE_PAIRS), .CP(COL_PAIRS)) u_loc (
        .syn    (syn),
        .byte_a (loc_byte),
        .bit_a  (loc_bit)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = chk_go;
        if (chk_go) begin
            res_d.status = cls_status;
            if (cls_status == ST_FIX) begin
                res_d.byte_a = loc_byte;
                res_d.bit_a  = loc_bit;
            end else begin
                res_d.byte_a = '0;
                res_d.bit_a  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        flip_mask = '0;
        if (res_q.status == ST_FIX) begin
            flip_mask = DW'(1) << res_q.bit_a;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_status = res_q.status;
    assign res_byte   = res_q.byte_a;
    assign res_bit    = res_q.bit_a;
    assign fix_out    = fix_in ^ flip_mask;
endmodule

// File: rtl/nand_ecc_locator_chk.sv
module nand_ecc_locator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_go,
    input logic        wide_mode,
    input logic [23:0] code_stored,
    input logic [23:0] code_fresh,
    input logic        res_valid,
    input logic [1:0]  res_status,
    input logic [8:0]  res_byte,
    input logic [2:0]  res_bit,
    input logic [7:0]  fix_in,
    input logic [7:0]  fix_out
);
    AST_VALID_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        chk_go |=> res_valid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_go |=> !res_valid); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_go |=> $stable(res_status) && $stable(res_byte) && $stable(res_bit)); // R9
    AST_SAME_CODES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_go && code_stored == code_fresh) |=> res_status == 2'd0); // R1
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_go && !wide_mode) |=> !res_byte[8]); // R5
    AST_ADDR_ZERO_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'd1 |-> (res_byte == 9'd0 && res_bit == 3'd0)); // R7
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'd1 |-> fix_out == fix_in); // R10
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        res_status == 2'd1 |-> $countones(fix_out ^ fix_in) == 1); // R10
endmodule

bind nand_ecc_locator nand_ecc_locator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chk_go(chk_go), .wide_mode(wide_mode),
    .code_stored(code_stored), .code_fresh(code_fresh),
    .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
    .res_bit(res_bit), .fix_in(fix_in), .fix_out(fix_out)
);

// File: tb/nand_ecc_locator_test.sv
module nand_ecc_locator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_go = 1'b0;
    logic        wide_mode = 1'b0;
    logic [23:0] code_stored = '0;
    logic [23:0] code_fresh = '0;
    logic [7:0]  fix_in = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;
    logic [7:0]  fix_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected registered state
    logic       e_valid = 0;
    logic [1:0] e_status = 0;
    int         e_byte = 0;
    int         e_bit = 0;

    always #10 clk = ~clk;

    nand_ecc_locator uut (
        .clk(clk), .rst_n(rst_n), .chk_go(chk_go), .wide_mode(wide_mode),
        .code_stored(code_stored), .code_fresh(code_fresh),
        .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
        .res_bit(res_bit), .fix_in(fix_in), .fix_out(fix_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // syndrome of a single data-bit fault at (byte a, bit b)
    function automatic logic [23:0] one_fault(input int a, input int b);
        logic [23:0] s = '0;
        for (int k = 0; k < 9; k++) s[2*k + ((a >> k) & 1)] = 1'b1;
        for (int j = 0; j < 3; j++) s[18 + 2*j + ((b >> j) & 1)] = 1'b1;
        return s;
    endfunction

    task automatic compare_outputs(input string stag);
        check("R9 valid", res_valid, e_valid);
        check(stag, res_status, e_status);
        check("R5 byte", res_byte, e_byte);
        check("R6 bit", res_bit, e_bit);
    endtask

    // one clock of stimulus; stag names the status requirement of the prior step
    task automatic step(input bit go, input bit wide, input logic [23:0] syn,
                        input logic [7:0] fin, inout string stag);
        logic [23:0] m;
        int ones;
        bit pok;
        int np;
        @(negedge clk);
        compare_outputs(stag);
        chk_go = go;
        wide_mode = wide;
        code_stored = 24'($urandom);
        code_fresh = code_stored ^ syn;
        fix_in = fin;
        #1;
        check("R10 fix", fix_out, (e_status == 2'd1) ? (fin ^ (8'd1 << e_bit)) : fin);
        e_valid = go;
        if (go) begin
            m = syn;
            if (!wide) m[17:16] = 2'b00;
            ones = 0;
            for (int i = 0; i < 24; i++) ones += m[i];
            pok = 1;
            for (int p = 0; p < 12; p++) begin
                if (!(p == 8 && !wide) && m[2*p] == m[2*p+1]) pok = 0;
            end
            np = wide ? 12 : 11;
            e_byte = 0; e_bit = 0;
            if (ones == 0) begin
                e_status = 0; stag = "R1 status";
            end else if (ones == 1) begin
                e_status = 2; stag = "R2 status";
            end else if (pok && ones == np) begin
                e_status = 1; stag = wide ? "R4 status" : "R3 status";
                for (int k = 0; k < (wide ? 9 : 8); k++) e_byte |= m[2*k+1] << k;
                e_bit = {m[23], m[21], m[19]};
            end else begin
                e_status = 3; stag = "R7 status";
            end
        end
    endtask

    initial begin
        string tag = "R11 status";
        logic [23:0] s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        compare_outputs("R11 status");
        // R1 clean, with idle hold afterwards (R9)
        step(1, 0, 24'h0, 8'h5A, tag);
        step(0, 0, 24'hFFFFFF, 8'h11, tag);
        // R2 code-field faults
        step(1, 1, 24'h000001, 8'h22, tag);
        step(1, 0, 24'h800000, 8'h33, tag);
        step(1, 1, 24'h020000, 8'h44, tag);
        // R8: bit 16 alone in narrow mode is masked -> clean
        step(1, 0, 24'h010000, 8'h55, tag);
        // R3 correctable in 256 mode, corners and random
        step(1, 0, one_fault(0, 0), 8'h00, tag);
        step(1, 0, one_fault(255, 7), 8'hFF, tag);
        step(1, 0, one_fault(170, 5), 8'hA5, tag);
        // R8: narrow mode with both top-pair bits set is masked, still correctable
        s = one_fault(77, 2); s[17:16] = 2'b11;
        step(1, 0, s, 8'h3C, tag);
        // R4 correctable in 512 mode
        step(1, 1, one_fault(511, 7), 8'h81, tag);
        step(1, 1, one_fault(256, 0), 8'h7E, tag);
        step(0, 1, 24'h0, 8'h99, tag);
        // R7: two-bit data fault
        step(1, 0, one_fault(3, 1) ^ one_fault(9, 6), 8'h12, tag);
        // R7: 11 ones but one pair both set and another both clear
        s = one_fault(40, 3); s[0] = 1'b1; s[1] = 1'b1; s[19:18] = 2'b00; s[2] = ~s[2];
        s[3] = ~s[3];
        step(1, 0, s, 8'h34, tag);
        // R7: narrow-size syndrome seen in wide mode (11 ones)
        s = one_fault(100, 4); s[17:16] = 2'b00;
        step(1, 1, s, 8'h56, tag);
        // R7: all ones
        step(1, 1, 24'hFFFFFF, 8'h78, tag);
        // back-to-back strobes with random faults and repair bytes (R10 with R9)
        for (int n = 0; n < 200; n++) begin
            int a = $urandom_range(0, 511);
            int b = $urandom_range(0, 7);
            bit w = n[0];
            int kind = $urandom_range(0, 3);
            if (kind == 0) s = one_fault(a, b);
            else if (kind == 1) s = 24'(1) << $urandom_range(0, 23);
            else if (kind == 2) s = one_fault(a, b) ^ (24'(1) << $urandom_range(0, 23));
            else s = 24'($urandom);
            step($urandom_range(0, 3) != 0, w, s, 8'($urandom), tag);
        end
        step(0, 0, 24'h0, 8'hC3, tag);
        step(0, 0, 24'h0, 8'h3C, tag);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule